// File: doc/BRIEF.md
# Serial Flash Continuous-Read Responder

This block sits on the device side of a serial peripheral bus and answers a single command: a sequential read of the main storage array. It runs on a fast system clock. The bus clock, select and data-in pins are oversampled through synchronizers, and the bus clock edges are recovered as one-cycle strobes. Once select falls, the block shifts in an opcode, a 24-bit start address and four filler bytes. It then serves bytes from an attached synchronous memory, most significant bit first. Each fetch drives an address out and takes data back one clock later.

The start address is split into a page number and a byte offset. Two layouts are supported, chosen by a configuration pin. The long layout has 528-byte pages, a 12-bit page field and a 10-bit offset. The short layout has 512-byte pages, a 12-bit page field and a 9-bit offset. An internal counter steps through the array. It rolls into the next page at the end of each page and returns to page 0 after the final page, without inserting clocks. Any other opcode is ignored, and raising select ends any operation at once.

Top module: `sflash_rd_resp`

## Requirements
- R1: After reset, and whenever select has not fallen since the last time it was high, `ser_oe` is 0 and no memory read is issued. Toggling the bus clock while select is high starts nothing.
- R2: With select low, `ser_in` is sampled on each rising bus clock edge, most significant bit first. Opcode 0xE8 selects the read. It is followed by exactly 3 address bytes and 4 filler bytes, which makes 64 rising edges before data.
- R3: Data bits change on falling bus clock edges, most significant bit first. The first bit and `ser_oe`=1 appear after the falling edge that follows the 64th rising edge. `ser_out` holds steady between falling edges.
- R4: In the long layout (`cfg_page528`=1), the page is address bits 21..10 and the offset is bits 9..0. Bits 23..22 are ignored.
- R5: In the short layout (`cfg_page528`=0), the page is address bits 20..9 and the offset is bits 8..0. Bits 23..21 are ignored.
- R6: In the long layout, the byte after offset 527 of a page is offset 0 of the next page, with no extra bus clocks.
- R7: In the short layout, the byte after offset 511 of a page is offset 0 of the next page, with no extra bus clocks.
- R8: The byte after the last offset of page 4095 is page 0, offset 0, in either layout, with no extra bus clocks.
- R9: In the long layout, a loaded start offset from 528 to 1023 is treated as 527. The following byte is then offset 0 of the next page.
- R10: With any opcode other than 0xE8, `ser_oe` stays 0 and no memory read is issued until select rises.
- R11: Select rising at any point returns the block to idle: `ser_oe` falls within 4 system clocks. The next falling edge of select starts a fresh command.
- R12: Each memory read is a one-cycle `mem_rd_en` pulse with `mem_addr` = {page, offset}. `mem_rdata` is expected one cycle later. One read is issued for the start byte, and one more is issued during the last bit of each byte sent, so a read of N bytes issues N+1 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_page528 | input | 1 | 1 selects 528-byte pages, 0 selects 512-byte pages; held stable while select is low |
| ser_clk | input | 1 | Bus clock (idles low) |
| sel_n | input | 1 | Active-low device select |
| ser_in | input | 1 | Serial data from host |
| ser_out | output | 1 | Serial data to host |
| ser_oe | output | 1 | Output enable for `ser_out`; 0 models high impedance |
| mem_rd_en | output | 1 | One-cycle read strobe to the storage array |
| mem_addr | output | 22 | Read address, page in bits 21..10, offset in bits 9..0 |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd_en` |

## Verification
The hardest cases to reach from the ports are the array-end wrap and the offset clamp. Walking the counter there one byte at a time would take millions of bus clocks. Instead, the stimulus loads start addresses directly at page 4095 a few bytes before the last offset in both layouts, and an out-of-range start offset in the long layout. Only a handful of bytes is then clocked through each boundary. The memory returns a value that depends on both page and offset, so a wrong page step, a wrong offset roll or a missed prefetch shows up as a wrong byte on `ser_out`.

// File: rtl/sflash_pkg.sv
package sflash_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_ADDR,
    ST_DUMMY,
    ST_DATA,
    ST_SKIP
  } rd_state_e;

  localparam logic [7:0] OP_CONT_READ = 8'hE8;

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
  parameter int                 WIDTH   = 1,
  parameter int                 STAGES  = 2,
  parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stage_d[s] = d_in;
    end else begin : g_rest
      assign stage_d[s] = stage_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= RST_VAL;
      end else begin
        stage_q[s] <= stage_d[s];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/sfr_cmd_fsm.sv
module sfr_cmd_fsm
  import sflash_pkg::*;
#(
  parameter int         AW         = 22,
  parameter int         CMD_BITS   = 8,
  parameter int         ADDR_BITS  = 24,
  parameter int         DUMMY_BITS = 32,
  parameter logic [7:0] OPCODE     = OP_CONT_READ
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_q,
  input  logic          sel_fall,
  input  logic          sck_rise,
  input  logic          sck_fall,
  input  logic          din_q,
  output rd_state_e     state_q,
  output logic [AW-1:0] addr_word,
  output logic          addr_load,
  output logic          live
);

  localparam int MAX_AD  = (ADDR_BITS > CMD_BITS) ? ADDR_BITS : CMD_BITS;
  localparam int MAX_BITS = (DUMMY_BITS > MAX_AD) ? DUMMY_BITS : MAX_AD;
  localparam int CNT_W   = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] CMD_END   = CNT_W'(CMD_BITS - 1);
  localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(ADDR_BITS - 1);
  localparam logic [CNT_W-1:0] DUMMY_END = CNT_W'(DUMMY_BITS - 1);

  rd_state_e        state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [AW-1:0]    shreg_q, shreg_d, shreg_nx;
  logic             load_q, load_d;
  logic             live_q, live_d;

  assign shreg_nx = {shreg_q[AW-2:0], din_q};

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    load_d  = 1'b0;
    live_d  = live_q;
    if (sel_q) begin
      state_d = ST_IDLE;
      live_d  = 1'b0;
      cnt_d   = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sel_fall) begin
            state_d = ST_CMD;
            cnt_d   = '0;
          end
        end
        ST_CMD: begin
          if (sck_rise) begin
            shreg_d = shreg_nx;
            if (cnt_q == CMD_END) begin
              cnt_d   = '0;
              state_d = (shreg_nx[CMD_BITS-1:0] == OPCODE[CMD_BITS-1:0]) ? ST_ADDR : ST_SKIP;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_ADDR: begin
          if (sck_rise) begin
            shreg_d = shreg_nx;
            if (cnt_q == ADDR_END) begin
              cnt_d   = '0;
              state_d = ST_DUMMY;
              load_d  = 1'b1;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DUMMY: begin
          if (sck_rise) begin
            if (cnt_q == DUMMY_END) begin
              cnt_d   = '0;
              state_d = ST_DATA;
            end else begin
              cnt_d = cnt_q + CNT_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (sck_fall) begin
            live_d = 1'b1;
          end
        end
        default: begin
          state_d = state_q;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      load_q  <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      load_q  <= load_d;
      live_q  <= live_d;
    end
  end

  assign addr_word = shreg_q;
  assign addr_load = load_q;
  assign live      = live_q;

endmodule

// File: rtl/sfr_addr_ctr.sv
module sfr_addr_ctr #(
  parameter int PAGE_W    = 12,
  parameter int OFF_W     = 10,
  parameter int LONG_SIZE = 528
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    step,
  input  logic                    long_mode,
  input  logic [PAGE_W+OFF_W-1:0] addr_word,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  output logic                    mem_rd_en
);

  localparam int MEM_AW = PAGE_W + OFF_W;
  localparam logic [OFF_W-1:0] LONG_LAST  = OFF_W'(LONG_SIZE - 1);
  localparam logic [OFF_W-1:0] SHORT_LAST = OFF_W'((1 << (OFF_W - 1)) - 1);

  logic [PAGE_W-1:0] page_q, page_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              long_q, long_d;
  logic              rd_q, rd_d;
  logic [OFF_W-1:0]  last_off;
  logic [OFF_W-1:0]  long_off_in;

  assign last_off    = long_q ? LONG_LAST : SHORT_LAST;
  assign long_off_in = addr_word[OFF_W-1:0];

  always_comb begin
    page_d = page_q;
    off_d  = off_q;
    long_d = long_q;
    rd_d   = 1'b0;
    if (load) begin
      long_d = long_mode;
      rd_d   = 1'b1;
      if (long_mode) begin
        page_d = addr_word[MEM_AW-1:OFF_W];
        off_d  = (long_off_in > LONG_LAST) ? LONG_LAST : long_off_in;
      end else begin
        page_d = addr_word[MEM_AW-2:OFF_W-1];
        off_d  = {1'b0, addr_word[OFF_W-2:0]};
      end
    end else if (step) begin
      rd_d = 1'b1;
      if (off_q == last_off) begin
        off_d  = '0;
        page_d = page_q + PAGE_W'(1);
      end else begin
        off_d = off_q + OFF_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= '0;
      off_q  <= '0;
      long_q <= 1'b0;
      rd_q   <= 1'b0;
    end else begin
      page_q <= page_d;
      off_q  <= off_d;
      long_q <= long_d;
      rd_q   <= rd_d;
    end
  end

  assign mem_addr  = {page_q, off_q};
  assign mem_rd_en = rd_q;

endmodule

// File: rtl/sfr_shift_out.sv
module sfr_shift_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_fall,
  input  logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              ser_out,
  output logic              step
);

  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sh_q, sh_d;
  logic [DATA_W-1:0] pf_q, pf_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              cap_q, cap_d;

  always_comb begin
    cap_d = mem_rd_en;
    pf_d  = cap_q ? mem_rdata : pf_q;
    sh_d  = sh_q;
    bit_d = bit_q;
    if (!active) begin
      bit_d = '0;
    end else if (sck_fall) begin
      bit_d = bit_q + BIT_W'(1);
      if (bit_q == '0) begin
        sh_d = pf_q;
      end else begin
        sh_d = {sh_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pf_q  <= '0;
      bit_q <= '0;
      cap_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      pf_q  <= pf_d;
      bit_q <= bit_d;
      cap_q <= cap_d;
    end
  end

  assign step    = active & sck_fall & (bit_q == LAST_BIT);
  assign ser_out = sh_q[DATA_W-1];

endmodule

// File: rtl/sflash_rd_resp.sv
module sflash_rd_resp
  import sflash_pkg::*;
#(
  parameter int PAGE_W      = 12,
  parameter int OFF_W       = 10,
  parameter int LONG_SIZE   = 528,
  parameter int DATA_W      = 8,
  parameter int ADDR_BYTES  = 3,
  parameter int DUMMY_BYTES = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_page528,
  input  logic                    ser_clk,
  input  logic                    sel_n,
  input  logic                    ser_in,
  output logic                    ser_out,
  output logic                    ser_oe,
  output logic                    mem_rd_en,
  output logic [PAGE_W+OFF_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]       mem_rdata
);

  localparam int MEM_AW     = PAGE_W + OFF_W;
  localparam int ADDR_BITS  = ADDR_BYTES * DATA_W;
  localparam int DUMMY_BITS = DUMMY_BYTES * DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic rst_sync_n;

  sfr_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (1'b1),
    .q     (rst_sync_n)
  );

  // pin synchronizers: {bus clock, select, data in}
  logic [2:0] pin_raw, pin_q;
  logic       sck_q, sel_q, din_q;
  logic       sck_prev, sel_prev;
  logic       sck_rise, sck_fall, sel_fall;

  assign pin_raw = {ser_clk, sel_n, ser_in};

  sfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_pin_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_in  (pin_raw),
    .q     (pin_q)
  );

  assign sck_q = pin_q[2];
  assign sel_q = pin_q[1];
  assign din_q = pin_q[0];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sck_prev <= 1'b0;
      sel_prev <= 1'b1;
    end else begin
      sck_prev <= sck_q;
      sel_prev <= sel_q;
    end
  end

  assign sck_rise = sck_q & ~sck_prev;
  assign sck_fall = ~sck_q & sck_prev;
  assign sel_fall = ~sel_q & sel_prev;

  // command sequencing
  rd_state_e         state_q;
  logic [MEM_AW-1:0] addr_word;
  logic              addr_load;
  logic              live;
  logic              in_data, in_skip;
  logic              step;

  sfr_cmd_fsm #(
    .AW         (MEM_AW),
    .CMD_BITS   (DATA_W),
    .ADDR_BITS  (ADDR_BITS),
    .DUMMY_BITS (DUMMY_BITS),
    .OPCODE     (OP_CONT_READ)
  ) u_cmd (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .sel_q     (sel_q),
    .sel_fall  (sel_fall),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .din_q     (din_q),
    .state_q   (state_q),
    .addr_word (addr_word),
    .addr_load (addr_load),
    .live      (live)
  );

  assign in_data = (state_q == ST_DATA);
  assign in_skip = (state_q == ST_SKIP);

  sfr_addr_ctr #(
    .PAGE_W    (PAGE_W),
    .OFF_W     (OFF_W),
    .LONG_SIZE (LONG_SIZE)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .load      (addr_load),
    .step      (step),
    .long_mode (cfg_page528),
    .addr_word (addr_word),
    .mem_addr  (mem_addr),
    .mem_rd_en (mem_rd_en)
  );

  sfr_shift_out #(.DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .active    (in_data),
    .sck_fall  (sck_fall),
    .mem_rd_en (mem_rd_en),
    .mem_rdata (mem_rdata),
    .ser_out   (ser_out),
    .step      (step)
  );

  assign ser_oe = live;

endmodule

// File: rtl/sflash_rd_resp_chk.sv
module sflash_rd_resp_chk #(
  parameter int OFF_W     = 10,
  parameter int LONG_SIZE = 528,
  parameter int MEM_AW    = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_q,
  input logic              sck_fall,
  input logic              in_skip,
  input logic              cfg_page528,
  input logic              ser_out,
  input logic              ser_oe,
  input logic              mem_rd_en,
  input logic [MEM_AW-1:0] mem_addr
);

  localparam logic [OFF_W-1:0] LONG_LAST = OFF_W'(LONG_SIZE - 1);

  assert_oe_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |=> !ser_oe);

  assert_rd_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> !mem_rd_en);

  assert_long_off_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && cfg_page528) |-> (mem_addr[OFF_W-1:0] <= LONG_LAST));

  assert_short_off_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && !cfg_page528) |-> !mem_addr[OFF_W-1]);

  assert_so_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_oe && $past(ser_oe) && !$past(sck_fall)) |-> $stable(ser_out));

  assert_skip_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_skip |-> (!ser_oe && !mem_rd_en));

endmodule

bind sflash_rd_resp sflash_rd_resp_chk #(
  .OFF_W     (OFF_W),
  .LONG_SIZE (LONG_SIZE),
  .MEM_AW    (MEM_AW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel_q       (sel_q),
  .sck_fall    (sck_fall),
  .in_skip     (in_skip),
  .cfg_page528 (cfg_page528),
  .ser_out     (ser_out),
  .ser_oe      (ser_oe),
  .mem_rd_en   (mem_rd_en),
  .mem_addr    (mem_addr)
);

// File: tb/sflash_rd_resp_bench.sv
module sflash_rd_resp_bench;

  localparam int H = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_page528 = 1'b1;
  logic        ser_clk = 1'b0;
  logic        sel_n = 1'b1;
  logic        ser_in = 1'b0;
  logic        ser_out, ser_oe, mem_rd_en;
  logic [21:0] mem_addr;
  logic [7:0]  mem_rdata;

  int tests = 0;
  int fails = 0;
  int rd_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sflash_rd_resp u_sflash_rd_resp (
    .clk (clk), .rst_n (rst_n), .cfg_page528 (cfg_page528),
    .ser_clk (ser_clk), .sel_n (sel_n), .ser_in (ser_in),
    .ser_out (ser_out), .ser_oe (ser_oe),
    .mem_rd_en (mem_rd_en), .mem_addr (mem_addr), .mem_rdata (mem_rdata)
  );

  function automatic logic [7:0] pat(int page, int off);
    return 8'((page * 7 + off * 3 + (off >> 8) * 91) & 255);
  endfunction

  // storage array model: registered read
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rdata <= pat(int'(mem_addr[21:10]), int'(mem_addr[9:0]));
      rd_cnt    <= rd_cnt + 1;
    end
  end

  task automatic tick(int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic xfer(logic b, output logic got, output logic oe);
    ser_in = b;
    tick(H);
    got = ser_out;
    oe  = ser_oe;
    ser_clk = 1'b1;
    tick(H);
    ser_clk = 1'b0;
  endtask

  // full transaction with behavioural expected-byte queue
  task automatic run_read(logic [7:0] op, logic long_pg, logic [23:0] addr,
                          int nbytes, string req);
    logic got, oe;
    logic [63:0] hdr;
    logic [7:0] exp_q[$];
    int page, off, size, rd0;
    bit pre_oe_bad;
    cfg_page528 = long_pg;
    hdr = {op, addr, 32'h0};
    if (op == 8'hE8) begin
      if (long_pg) begin
        page = int'((addr >> 10) & 24'hFFF); off = int'(addr & 24'h3FF);
        if (off > 527) off = 527;
        size = 528;
      end else begin
        page = int'((addr >> 9) & 24'hFFF); off = int'(addr & 24'h1FF);
        size = 512;
      end
      for (int k = 0; k < nbytes; k++) begin
        exp_q.push_back(pat(page, off));
        off++;
        if (off == size) begin
          off = 0;
          page = (page + 1) % 4096;
        end
      end
    end
    rd0 = rd_cnt;
    tick(H);
    sel_n = 1'b0;
    tick(H);
    pre_oe_bad = 0;
    for (int i = 63; i >= 0; i--) begin
      xfer(hdr[i], got, oe);
      if (oe) pre_oe_bad = 1;
    end
    chk(!pre_oe_bad, "R2 header oe", int'(pre_oe_bad), 0);
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] b;
      logic oe_all;
      oe_all = 1'b1;
      b = '0;
      for (int j = 0; j < 8; j++) begin
        xfer(1'b0, got, oe);
        b = {b[6:0], got};
        oe_all = oe_all & oe;
      end
      if (op == 8'hE8)
        chk({oe_all, b} == {1'b1, exp_q[k]}, req, int'({oe_all, b}), int'({1'b1, exp_q[k]}));
      else
        chk(!oe, req, int'(oe), 0);
    end
    if (op == 8'hE8)
      chk(rd_cnt - rd0 == nbytes + 1, "R12 read count", rd_cnt - rd0, nbytes + 1);
    else
      chk(rd_cnt == rd0, "R10 no read", rd_cnt - rd0, 0);
    tick(H);
    sel_n = 1'b1;
    tick(4);
    chk(!ser_oe, "R11 oe after select high", int'(ser_oe), 0);
    tick(H);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    logic got, oe;
    int rd0;
    tick(5);
    rst_n = 1'b1;
    tick(10);
    // R1: quiet after reset
    chk(!ser_oe, "R1 reset oe", int'(ser_oe), 0);
    chk(!mem_rd_en && rd_cnt == 0, "R1 reset read", rd_cnt, 0);

    // R1: bus clock with select high starts nothing
    rd0 = rd_cnt;
    for (int i = 7; i >= 0; i--) xfer(8'hE8 >> i, got, oe);
    for (int i = 0; i < 80; i++) xfer(1'b0, got, oe);
    chk(!ser_oe && rd_cnt == rd0, "R1 select high ignored", rd_cnt - rd0, 0);

    // R2 R3 R4 R6 R12: long pages, cross page 5 -> 6
    run_read(8'hE8, 1'b1, 24'hC00000 | (24'd5 << 10) | 24'd520, 16, "R6 long crossover");
    // R5 R7: short pages, upper bits ignored, cross page 7 -> 8
    run_read(8'hE8, 1'b0, 24'hE00000 | (24'd7 << 9) | 24'd505, 10, "R7 short crossover");
    // R8: array end wrap, both layouts
    run_read(8'hE8, 1'b1, (24'd4095 << 10) | 24'd525, 6, "R8 long array wrap");
    run_read(8'hE8, 1'b0, (24'd4095 << 9) | 24'd509, 5, "R8 short array wrap");
    // R9: out-of-range long offset clamps
    run_read(8'hE8, 1'b1, (24'd9 << 10) | 24'd900, 3, "R9 offset clamp");
    // R4: bit 10 distinguishes page in long layout
    run_read(8'hE8, 1'b1, (24'd3 << 10) | 24'd0, 4, "R4 long field split");
    // R10: other opcode ignored
    run_read(8'h0B, 1'b1, 24'h000010, 4, "R10 other opcode");

    // R11: abort inside the address phase, then a fresh command
    rd0 = rd_cnt;
    sel_n = 1'b0;
    tick(H);
    for (int i = 7; i >= 0; i--) xfer(8'hE8 >> i, got, oe);
    for (int i = 0; i < 12; i++) xfer(1'b1, got, oe);
    sel_n = 1'b1;
    tick(4);
    chk(!ser_oe && rd_cnt == rd0, "R11 abort mid address", rd_cnt - rd0, 0);
    tick(H);
    run_read(8'hE8, 1'b1, 24'h000000, 6, "R11 fresh command");
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule